// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block drains a sector buffer through one of two paths. It keeps a remaining-byte counter, a buffer byte pointer and a destination address register. Software loads these registers and then starts a transfer. From then on, data can leave in two ways. A DMA path copies 16-bit words into one of three destination memories. Each command moves one burst, and the final burst is shorter than the others. A host path hands out one big-endian word per read request.

Both paths watch the counter. When the transfer runs out they set the end flags, drop the ready and busy flags, and can raise a level-5 interrupt pulse. The 3-bit destination mode field decides two things: which memory a DMA burst writes, and which reader (main or sub) may pull words through the host path.

The buffer is read through a combinational port: the block presents a byte address and gets back the big-endian word starting there. Destination memories take one word write per cycle through a request port with a ready input.

Top module: `sbx_engine`

## Requirements
- R1: After reset, the count, buffer pointer and destination registers are zero. busy, end_flag, data_ready and irq5 are 0, stat_xfer_n and stat_end_n are 1, and no destination write is requested.
- R2: A start pulse in idle sets busy and data_ready, clears end_flag, and drives stat_xfer_n low (active-low "transfer running").
- R3: A dma_go pulse starts a burst only when busy is set and mode_sel is 4 (PCM memory, dst_sel=2), 5 (program memory, dst_sel=0) or 7 (word memory, dst_sel=1). Any other mode, or a go while idle-not-busy, changes nothing. A burst is 256 words when the count exceeds 512. Otherwise it is the final burst of (count+1)/2 words. One write is presented per cycle and held unchanged while dst_ready is low.
- R4: After a non-final burst the count drops by 512 and the pointer advances by 512 modulo 65536. After the final burst the count is zero and the pointer has advanced by twice the word count.
- R5: Destination byte address of word i is base+2i. base is dest×8 for program and word memory and dest×4 for PCM. After a burst, dest advances by the bytes moved divided by 8, or by 4 for PCM (truncated, modulo 65536).
- R6: Word memory split mode (wram_split=1) uses the low 14 dest bits, with dst_bank equal to the inverse of wram_bank. Full mode uses 15 bits. PCM uses 10 bits. Write data is the buffer word at pointer+2i.
- R7: Every rd_req gives rd_valid one cycle later. The read returns 0 and changes no state unless busy is set, no burst, start or go is active, and mode_sel is 3 for the sub reader (rd_is_sub=1) or 2 for the main reader.
- R8: An accepted read returns the buffer word at the pointer, subtracts 2 from the count and adds 2 to the pointer. If the count was 2 or less, the count becomes zero and the transfer ends.
- R9: At transfer end, busy clears, end_flag sets, data_ready clears and stat_xfer_n returns high.
- R10: With end_irq_en set, transfer end drives stat_end_n low and pulses irq5 for one cycle if irq5_mask is set. end_ack returns stat_end_n high. With end_irq_en clear, neither changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_count | input | 1 | Load byte count from ld_value (idle only) |
| ld_addr | input | 1 | Load buffer pointer from ld_value (idle only) |
| ld_dest | input | 1 | Load destination register from ld_value (idle only) |
| ld_value | input | 16 | Value for the load strobes |
| start | input | 1 | Begin a transfer |
| dma_go | input | 1 | Run one DMA burst |
| mode_sel | input | 3 | Destination mode field |
| wram_split | input | 1 | Word memory split mode |
| wram_bank | input | 1 | Word memory bank bit (inverted for the write) |
| end_irq_en | input | 1 | Enable end-of-transfer interrupt flag |
| irq5_mask | input | 1 | Mask bit for the level-5 interrupt |
| end_ack | input | 1 | Clear the end interrupt flag (sets stat_end_n) |
| rd_req | input | 1 | Host read request |
| rd_is_sub | input | 1 | Reader identity: 1 sub, 0 main |
| rd_valid | output | 1 | Host read response strobe |
| rd_data | output | 16 | Host read word |
| buf_raddr | output | 16 | Buffer byte address |
| buf_rdata | input | 16 | Buffer word {byte[a], byte[a+1]} |
| dst_we | output | 1 | Destination write request |
| dst_sel | output | 2 | Destination memory: 0 program, 1 word, 2 PCM |
| dst_bank | output | 1 | Word memory bank in split mode |
| dst_waddr | output | 20 | Destination byte address |
| dst_wdata | output | 16 | Destination write data |
| dst_ready | input | 1 | Destination accepts the write |
| cur_count | output | 16 | Remaining byte count |
| cur_addr | output | 16 | Buffer pointer |
| cur_dest | output | 16 | Destination address register |
| busy | output | 1 | Transfer active |
| end_flag | output | 1 | Transfer ended |
| data_ready | output | 1 | Data ready for the readers |
| stat_xfer_n | output | 1 | Low while a transfer runs |
| stat_end_n | output | 1 | Low when an end interrupt is pending |
| irq5 | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is a long burst whose buffer pointer crosses 0xFFFF while the destination stalls at varied word positions. This requires both a count above 512 and a pointer loaded just below the wrap. The stimulus loads a 1000-byte count at pointer 0xFFF0. It then toggles dst_ready on a three-cycle pattern unrelated to the word index, so stalls fall across the burst. The final short burst, the odd-count PCM burst and the zero-length burst exercise the (count+1)/2 rounding. The per-cycle reference model checks each presented address and data word.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    typedef enum logic [1:0] {
        TGT_PRG  = 2'd0,
        TGT_WORD = 2'd1,
        TGT_PCM  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic ok;
        tgt_e tgt;
    } tgt_dec_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } st_e;

    localparam logic [2:0] MODE_MAIN_RD = 3'd2;
    localparam logic [2:0] MODE_SUB_RD  = 3'd3;
    localparam logic [2:0] MODE_PCM     = 3'd4;
    localparam logic [2:0] MODE_PRG     = 3'd5;
    localparam logic [2:0] MODE_WORD    = 3'd7;

    // Map the mode field onto a DMA target; other codes are not DMA modes.
    function automatic tgt_dec_t decode_mode(input logic [2:0] m);
        tgt_dec_t d;
        d.ok  = 1'b1;
        d.tgt = TGT_PRG;
        unique case (m)
            MODE_PCM:  d.tgt = TGT_PCM;
            MODE_PRG:  d.tgt = TGT_PRG;
            MODE_WORD: d.tgt = TGT_WORD;
            default:   d.ok  = 1'b0;
        endcase
        return d;
    endfunction

    // Destination register granule as a power of two: 4 bytes for PCM, 8 otherwise.
    function automatic logic [1:0] unit_shift(input tgt_e t);
        return (t == TGT_PCM) ? 2'd2 : 2'd3;
    endfunction

    // Reader whose mode code opens the host path.
    function automatic logic [2:0] reader_mode(input logic is_sub);
        return is_sub ? MODE_SUB_RD : MODE_MAIN_RD;
    endfunction

endpackage

// File: rtl/sbx_burst_plan.sv
module sbx_burst_plan #(
    parameter int CNT_W       = 16,
    parameter int BURST_WORDS = 256,
    parameter int IDX_W       = 9
) (
    input  logic [CNT_W-1:0] count,
    output logic [IDX_W-1:0] words,
    output logic             is_final
);
    localparam logic [CNT_W:0] CAP_BYTES = (CNT_W+1)'(2 * BURST_WORDS);

    logic [CNT_W:0] half_up;

    always_comb begin
        half_up  = ({1'b0, count} + (CNT_W+1)'(1)) >> 1;
        is_final = ({1'b0, count} <= CAP_BYTES);
        words    = is_final ? IDX_W'(half_up) : IDX_W'(BURST_WORDS);
    end
endmodule

// File: rtl/sbx_dst_map.sv
module sbx_dst_map
    import sbx_pkg::*;
#(
    parameter int DEST_W      = 16,
    parameter int AW          = 20,
    parameter int IDX_W       = 9,
    parameter int SPLIT_BITS  = 14,
    parameter int FULL_BITS   = 15,
    parameter int PCM_BITS    = 10
) (
    input  tgt_e              tgt,
    input  logic [DEST_W-1:0] dest,
    input  logic              split,
    input  logic              bank_bit,
    input  logic [IDX_W-1:0]  idx,
    output logic [AW-1:0]     waddr,
    output logic              bank
);
    logic [AW-1:0] base;

    always_comb begin
        unique case (tgt)
            TGT_WORD: begin
                if (split) base = AW'({dest[SPLIT_BITS-1:0], 3'b000});
                else       base = AW'({dest[FULL_BITS-1:0], 3'b000});
            end
            TGT_PCM:   base = AW'({dest[PCM_BITS-1:0], 2'b00});
            default:   base = AW'({dest, 3'b000});
        endcase
        bank  = (tgt == TGT_WORD) && split && !bank_bit;
        waddr = base + AW'({idx, 1'b0});
    end
endmodule

// File: rtl/sbx_host_port.sv
module sbx_host_port
    import sbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic          rd_is_sub,
    input  logic [2:0]    mode_sel,
    input  logic          path_open,
    input  logic [DW-1:0] word_in,
    output logic          accept,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    always_comb begin
        accept = rd_req && path_open && (mode_sel == reader_mode(rd_is_sub));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= accept ? word_in : '0;
        end
    end
endmodule

// File: rtl/sbx_engine.sv
module sbx_engine
    import sbx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BURST_WORDS = 256,
    parameter int DST_AW      = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_count,
    input  logic              ld_addr,
    input  logic              ld_dest,
    input  logic [CNT_W-1:0]  ld_value,
    input  logic              start,
    input  logic              dma_go,
    input  logic [2:0]        mode_sel,
    input  logic              wram_split,
    input  logic              wram_bank,
    input  logic              end_irq_en,
    input  logic              irq5_mask,
    input  logic              end_ack,
    input  logic              rd_req,
    input  logic              rd_is_sub,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [CNT_W-1:0]  buf_raddr,
    input  logic [15:0]       buf_rdata,
    output logic              dst_we,
    output logic [1:0]        dst_sel,
    output logic              dst_bank,
    output logic [DST_AW-1:0] dst_waddr,
    output logic [15:0]       dst_wdata,
    input  logic              dst_ready,
    output logic [CNT_W-1:0]  cur_count,
    output logic [CNT_W-1:0]  cur_addr,
    output logic [CNT_W-1:0]  cur_dest,
    output logic              busy,
    output logic              end_flag,
    output logic              data_ready,
    output logic              stat_xfer_n,
    output logic              stat_end_n,
    output logic              irq5
);
    localparam int IDX_W = $clog2(BURST_WORDS) + 1;
    localparam logic [CNT_W-1:0] BURST_BYTES = CNT_W'(2 * BURST_WORDS);
    localparam logic [CNT_W-1:0] RD_STEP     = CNT_W'(2);

    st_e              state;
    logic [CNT_W-1:0] count_q, addr_q, dest_q;
    logic [IDX_W-1:0] len_q, idx_q;
    logic             final_q;
    tgt_e             tgt_q;

    tgt_dec_t         dec;
    logic [IDX_W-1:0] plan_words;
    logic             plan_final;
    logic             in_idle, go_ok, host_open, host_acc;
    logic             burst_done, rd_end, end_now;
    logic [CNT_W-1:0] moved_bytes, dest_step;

    sbx_burst_plan #(
        .CNT_W(CNT_W), .BURST_WORDS(BURST_WORDS), .IDX_W(IDX_W)
    ) u_plan (
        .count(count_q), .words(plan_words), .is_final(plan_final)
    );

    sbx_dst_map #(
        .DEST_W(CNT_W), .AW(DST_AW), .IDX_W(IDX_W)
    ) u_map (
        .tgt(tgt_q), .dest(dest_q), .split(wram_split), .bank_bit(wram_bank),
        .idx(idx_q), .waddr(dst_waddr), .bank(dst_bank)
    );

    sbx_host_port #(.DW(16)) u_host (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_is_sub(rd_is_sub),
        .mode_sel(mode_sel), .path_open(host_open), .word_in(buf_rdata),
        .accept(host_acc), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always_comb begin
        dec         = decode_mode(mode_sel);
        in_idle     = (state == ST_IDLE);
        go_ok       = in_idle && !start && dma_go && busy && dec.ok;
        host_open   = in_idle && !start && !dma_go && busy;
        burst_done  = (state == ST_BURST) &&
                      ((len_q == '0) || (dst_ready && (idx_q == len_q - IDX_W'(1))));
        rd_end      = host_acc && (count_q <= RD_STEP);
        end_now     = (burst_done && final_q) || rd_end;
        moved_bytes = CNT_W'({len_q, 1'b0});
        dest_step   = moved_bytes >> unit_shift(tgt_q);
        buf_raddr   = (state == ST_BURST) ? addr_q + CNT_W'({idx_q, 1'b0}) : addr_q;
        dst_we      = (state == ST_BURST) && (len_q != '0);
        dst_sel     = tgt_q;
        dst_wdata   = buf_rdata;
        stat_xfer_n = ~busy;
        cur_count   = count_q;
        cur_addr    = addr_q;
        cur_dest    = dest_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            count_q    <= '0;
            addr_q     <= '0;
            dest_q     <= '0;
            len_q      <= '0;
            idx_q      <= '0;
            final_q    <= 1'b0;
            tgt_q      <= TGT_PRG;
            busy       <= 1'b0;
            end_flag   <= 1'b0;
            data_ready <= 1'b0;
            stat_end_n <= 1'b1;
            irq5       <= 1'b0;
        end else begin
            irq5 <= 1'b0;
            if (end_ack) stat_end_n <= 1'b1;

            if (state == ST_BURST) begin
                if (burst_done) begin
                    state   <= ST_IDLE;
                    addr_q  <= addr_q + moved_bytes;
                    dest_q  <= dest_q + dest_step;
                    count_q <= final_q ? '0 : count_q - BURST_BYTES;
                end else if (dst_ready) begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end else begin
                if (start) begin
                    busy       <= 1'b1;
                    end_flag   <= 1'b0;
                    data_ready <= 1'b1;
                end else if (go_ok) begin
                    state   <= ST_BURST;
                    len_q   <= plan_words;
                    final_q <= plan_final;
                    tgt_q   <= dec.tgt;
                    idx_q   <= '0;
                end else if (host_acc) begin
                    count_q <= rd_end ? '0 : count_q - RD_STEP;
                    addr_q  <= addr_q + RD_STEP;
                end
                if (ld_count) count_q <= ld_value;
                if (ld_addr)  addr_q  <= ld_value;
                if (ld_dest)  dest_q  <= ld_value;
            end

            if (end_now) begin
                busy       <= 1'b0;
                end_flag   <= 1'b1;
                data_ready <= 1'b0;
                if (end_irq_en) begin
                    stat_end_n <= 1'b0;
                    irq5       <= irq5_mask;
                end
            end
        end
    end
endmodule

// File: rtl/sbx_engine_chk.sv
module sbx_engine_chk #(
    parameter int CNT_W  = 16,
    parameter int DST_AW = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             end_flag,
    input logic             data_ready,
    input logic             stat_end_n,
    input logic             irq5,
    input logic             dst_we,
    input logic             dst_ready,
    input logic [CNT_W-1:0] buf_raddr,
    input logic             rd_valid,
    input logic [15:0]      rd_data
);
    AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        dst_we |-> busy);  // R3

    AST_STALL_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
        (dst_we && !dst_ready) |=> (dst_we && $stable(buf_raddr)));  // R3

    AST_END_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (end_flag && !data_ready));  // R9

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        irq5 |-> (!busy && $past(busy) && !stat_end_n));  // R10

    AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !$past(busy)) |-> (rd_data == 16'h0000));  // R7
endmodule

bind sbx_engine sbx_engine_chk #(.CNT_W(CNT_W), .DST_AW(DST_AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .end_flag(end_flag),
    .data_ready(data_ready), .stat_end_n(stat_end_n), .irq5(irq5),
    .dst_we(dst_we), .dst_ready(dst_ready), .buf_raddr(buf_raddr),
    .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/sbx_engine_bench.sv
module sbx_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_count = 0, ld_addr = 0, ld_dest = 0;
    logic [15:0] ld_value = '0;
    logic        start = 0, dma_go = 0;
    logic [2:0]  mode_sel = '0;
    logic        wram_split = 0, wram_bank = 0;
    logic        end_irq_en = 0, irq5_mask = 0, end_ack = 0;
    logic        rd_req = 0, rd_is_sub = 0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [15:0] buf_raddr;
    logic [15:0] buf_rdata;
    logic        dst_we;
    logic [1:0]  dst_sel;
    logic        dst_bank;
    logic [19:0] dst_waddr;
    logic [15:0] dst_wdata;
    logic        dst_ready = 1'b1;
    logic [15:0] cur_count, cur_addr, cur_dest;
    logic        busy, end_flag, data_ready, stat_xfer_n, stat_end_n, irq5;

    int n_chk = 0, n_err = 0, cyc = 0, cyc_n = 0;
    bit stall_en = 0, finished = 0;
    int wr_cnt = 0, first_wa = -1, first_bank = -1;

    // Reference model state
    int m_cnt, m_addr, m_dest, m_len, m_idx, m_tgt, m_rd;
    bit m_busy, m_end, m_rdy, m_endn, m_irq, m_burst, m_fin, m_rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bb(int a);
        return ((a * 7) ^ ((a >> 8) * 13) ^ 8'h5A) & 255;
    endfunction
    function automatic int word_at(int a);
        return (bb(a & 16'hFFFF) << 8) | bb((a + 1) & 16'hFFFF);
    endfunction

    assign buf_rdata = 16'(word_at(int'(buf_raddr)));

    sbx_engine u_sbx_engine (
        .clk(clk), .rst(rst), .ld_count(ld_count), .ld_addr(ld_addr), .ld_dest(ld_dest),
        .ld_value(ld_value), .start(start), .dma_go(dma_go), .mode_sel(mode_sel),
        .wram_split(wram_split), .wram_bank(wram_bank), .end_irq_en(end_irq_en),
        .irq5_mask(irq5_mask), .end_ack(end_ack), .rd_req(rd_req), .rd_is_sub(rd_is_sub),
        .rd_valid(rd_valid), .rd_data(rd_data), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .dst_we(dst_we), .dst_sel(dst_sel), .dst_bank(dst_bank), .dst_waddr(dst_waddr),
        .dst_wdata(dst_wdata), .dst_ready(dst_ready), .cur_count(cur_count),
        .cur_addr(cur_addr), .cur_dest(cur_dest), .busy(busy), .end_flag(end_flag),
        .data_ready(data_ready), .stat_xfer_n(stat_xfer_n), .stat_end_n(stat_end_n),
        .irq5(irq5)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Expected combinational outputs from model state
    function automatic int exp_raddr();
        return m_burst ? ((m_addr + 2 * m_idx) & 16'hFFFF) : m_addr;
    endfunction
    function automatic int exp_waddr();
        int base;
        if (m_tgt == 1) base = wram_split ? ((m_dest & 16'h3FFF) << 3) : ((m_dest & 16'h7FFF) << 3);
        else if (m_tgt == 2) base = (m_dest & 16'h03FF) << 2;
        else base = m_dest << 3;
        return (base + 2 * m_idx) & 20'hFFFFF;
    endfunction

    // Behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        bit endit;
        int bytes;
        endit = 0;
        if (rst) begin
            m_cnt = 0; m_addr = 0; m_dest = 0; m_len = 0; m_idx = 0; m_tgt = 0; m_rd = 0;
            m_busy = 0; m_end = 0; m_rdy = 0; m_endn = 1; m_irq = 0; m_burst = 0;
            m_fin = 0; m_rv = 0;
        end else begin
            m_irq = 0;
            m_rv  = rd_req;
            m_rd  = 0;
            if (end_ack) m_endn = 1;
            if (m_burst) begin
                if (m_len == 0 || (dst_ready && m_idx == m_len - 1)) begin
                    m_burst = 0;
                    bytes  = 2 * m_len;
                    m_addr = (m_addr + bytes) & 16'hFFFF;
                    m_dest = (m_dest + (bytes >> ((m_tgt == 2) ? 2 : 3))) & 16'hFFFF;
                    if (m_fin) begin m_cnt = 0; endit = 1; end
                    else m_cnt = m_cnt - 512;
                end else if (dst_ready) m_idx++;
            end else begin
                if (start) begin
                    m_busy = 1; m_end = 0; m_rdy = 1;
                end else if (dma_go) begin
                    if (m_busy && (mode_sel == 4 || mode_sel == 5 || mode_sel == 7)) begin
                        m_fin   = (m_cnt <= 512);
                        m_len   = m_fin ? (m_cnt + 1) / 2 : 256;
                        m_idx   = 0;
                        m_burst = 1;
                        m_tgt   = (mode_sel == 4) ? 2 : (mode_sel == 7) ? 1 : 0;
                    end
                end else if (rd_req && m_busy && mode_sel == (rd_is_sub ? 3 : 2)) begin
                    m_rd = word_at(m_addr);
                    if (m_cnt <= 2) begin m_cnt = 0; endit = 1; end
                    else m_cnt = m_cnt - 2;
                    m_addr = (m_addr + 2) & 16'hFFFF;
                end
                if (ld_count) m_cnt  = ld_value;
                if (ld_addr)  m_addr = ld_value;
                if (ld_dest)  m_dest = ld_value;
            end
            if (endit) begin
                m_busy = 0; m_end = 1; m_rdy = 0;
                if (end_irq_en) begin m_endn = 0; m_irq = irq5_mask; end
            end
        end
    end

    // Per-cycle comparison, a quarter period after the rising edge
    always @(posedge clk) begin
        #(QTR);
        cyc++;
        if (!rst) begin
            chk("R4 count", cur_count, m_cnt);
            chk("R4 pointer", cur_addr, m_addr);
            chk("R5 dest", cur_dest, m_dest);
            chk("R9 busy", busy, m_busy);
            chk("R9 end_flag", end_flag, m_end);
            chk("R2 data_ready", data_ready, m_rdy);
            chk("R9 stat_xfer_n", stat_xfer_n, !m_busy);
            chk("R10 stat_end_n", stat_end_n, m_endn);
            chk("R10 irq5", irq5, m_irq);
            chk("R3 dst_we", dst_we, m_burst && m_len != 0);
            chk("R7 rd_valid", rd_valid, m_rv);
            chk("R8 rd_data", rd_data, m_rd);
            if (m_burst && m_len != 0) begin
                chk("R6 buf_raddr", buf_raddr, exp_raddr());
                chk("R5 dst_waddr", dst_waddr, exp_waddr());
                chk("R6 dst_wdata", dst_wdata, word_at(exp_raddr()));
                chk("R3 dst_sel", dst_sel, m_tgt);
                chk("R6 dst_bank", dst_bank, (m_tgt == 1 && wram_split) ? !wram_bank : 0);
            end
            if (dst_we && dst_ready) begin
                if (first_wa < 0) begin first_wa = dst_waddr; first_bank = dst_bank; end
                wr_cnt++;
            end
        end
        if (cyc > 60000 && !finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=%0d expected<=60000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    always @(negedge clk) begin
        cyc_n++;
        dst_ready = stall_en ? ((cyc_n % 3) != 2) : 1'b1;
    end

    task automatic nclk();
        @(negedge clk);
    endtask
    task automatic load(input int kind, input int v);
        ld_value = 16'(v);
        if (kind == 0) ld_count = 1; else if (kind == 1) ld_addr = 1; else ld_dest = 1;
        nclk();
        ld_count = 0; ld_addr = 0; ld_dest = 0;
    endtask
    task automatic setup(input int c, input int a, input int d);
        load(0, c); load(1, a); load(2, d);
        start = 1; nclk(); start = 0;
    endtask
    task automatic host_read(input bit sub);
        rd_req = 1; rd_is_sub = sub; nclk(); rd_req = 0;
    endtask
    task automatic burst();
        wr_cnt = 0; first_wa = -1; first_bank = -1;
        dma_go = 1; nclk(); dma_go = 0;
        while (dst_we) nclk();
        nclk();
    endtask

    initial begin
        repeat (3) nclk();
        rst = 0;
        nclk();
        // R1 reset state
        chk("R1 count", cur_count, 0);
        chk("R1 busy", busy, 0);
        chk("R1 stat_xfer_n", stat_xfer_n, 1);
        chk("R1 stat_end_n", stat_end_n, 1);
        chk("R1 dst_we", dst_we, 0);

        // R7 refused while not busy
        mode_sel = 3'd2;
        host_read(0);
        chk("R7 idle read valid", rd_valid, 1);
        chk("R7 idle read data", rd_data, 0);

        // Host path with interrupt
        end_irq_en = 1; irq5_mask = 1;
        setup(6, 16'h0010, 0);
        chk("R2 busy", busy, 1);
        chk("R2 data_ready", data_ready, 1);
        chk("R2 stat_xfer_n", stat_xfer_n, 0);
        host_read(1);
        chk("R7 wrong reader data", rd_data, 0);
        chk("R7 wrong reader count", cur_count, 6);
        host_read(0);
        chk("R8 word", rd_data, word_at(16'h0010));
        chk("R8 count", cur_count, 4);
        chk("R8 pointer", cur_addr, 16'h0012);
        host_read(0);
        host_read(0);
        chk("R8 end count", cur_count, 0);
        chk("R9 busy clear", busy, 0);
        chk("R9 end flag", end_flag, 1);
        chk("R10 irq pulse", irq5, 1);
        chk("R10 end flag low", stat_end_n, 0);
        nclk();
        chk("R10 irq one cycle", irq5, 0);
        end_ack = 1; nclk(); end_ack = 0;
        chk("R10 ack", stat_end_n, 1);

        // Long DMA into program memory, pointer wrap, stalls
        end_irq_en = 0; stall_en = 1; mode_sel = 3'd5;
        setup(1000, 16'hFFF0, 16'h0100);
        burst();
        chk("R3 full burst words", wr_cnt, 256);
        chk("R5 prog base", first_wa, 20'h00800);
        chk("R4 count after burst", cur_count, 488);
        chk("R4 pointer wrap", cur_addr, 16'h01F0);
        chk("R5 dest step", cur_dest, 16'h0140);
        chk("R9 still busy", busy, 1);
        burst();
        chk("R3 final burst words", wr_cnt, 244);
        chk("R4 final count", cur_count, 0);
        chk("R4 final pointer", cur_addr, 16'h03D8);
        chk("R5 final dest", cur_dest, 16'h017D);
        chk("R9 end after dma", end_flag, 1);
        chk("R10 no irq flag when disabled", stat_end_n, 1);

        // PCM, odd count, 10-bit mask
        stall_en = 0; mode_sel = 3'd4;
        setup(7, 16'h0020, 16'h05FE);
        burst();
        chk("R3 odd words", wr_cnt, 4);
        chk("R6 pcm mask", first_wa, 20'h007F8);
        chk("R5 pcm dest", cur_dest, 16'h0600);
        chk("R4 pcm pointer", cur_addr, 16'h0028);

        // Word memory split and full
        mode_sel = 3'd7; wram_split = 1; wram_bank = 1;
        setup(4, 0, 16'hC001);
        burst();
        chk("R6 split addr", first_wa, 8);
        chk("R6 split bank", first_bank, 0);
        wram_split = 0;
        setup(4, 0, 16'h8002);
        burst();
        chk("R6 full addr", first_wa, 16);

        // Zero-length final burst
        mode_sel = 3'd5;
        setup(0, 16'h0100, 0);
        burst();
        chk("R3 zero words", wr_cnt, 0);
        chk("R9 zero ends", busy, 0);

        // Non-DMA mode ignores go
        mode_sel = 3'd3;
        setup(10, 0, 0);
        burst();
        chk("R3 bad mode writes", wr_cnt, 0);
        chk("R3 bad mode count", cur_count, 10);
        chk("R3 bad mode busy", busy, 1);

        repeat (2) nclk();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule